// File: doc/BRIEF.md
# Multicore Boot Release Controller

This block is the configuration window that a four-core processor cluster uses to bring secondary cores out of their held state. Software reaches it over a simple 32-bit register bus with a 1 KiB window. Three registers hold real state: a general control word, a standby flag and the address at which a released core begins execution. Software starts a core by writing any nonzero value to that core's reset control register. The block then raises a single-cycle start request for that core, together with the stored entry address and the exception level the core must start in.

Several registers exist only so that boot software reads the values it expects. These are the cluster and system reset words, the per-core reset, control and status words, and the clock gating word. Each returns a fixed "already running" value and ignores writes. The debug and 64-bit counter offsets decode, read as zero and raise an unimplemented pulse. Every other offset, and every access that is not 32-bit aligned, raises an address-error pulse.

Top module: `boot_release_ctrl`

## Requirements
- R1: After reset the general control word reads 0x00000020, the standby flag reads 0 and the entry address reads 0, and no start request, unimplemented pulse or address-error pulse is active.
- R2: General control (0x184), standby flag (0x1A0) and entry address (0x1A4) are full 32-bit registers. A write takes effect at the edge of its write strobe, and a later read returns the written value.
- R3: A write with nonzero data to core n's reset control register, at offset 0x40 + n*0x40, sets bit n of `start_req` high for exactly the one cycle after the write edge. No other bit is set. In that cycle `start_addr` equals the stored entry address and `start_el` equals 3.
- R4: A write of zero to a core reset control register produces no start request.
- R5: Reads of a core reset control register (group base + 0) return 0x3. Reads of the cluster reset word (0x000) and the system reset word (0x140) return 0x1.
- R6: Core status registers (group base + 8) read 0x1, core control registers (group base + 4) read 0, and the gating word (0x144) reads 0x10F. Writes to any of these, and to the cluster and system reset words, leave their read values unchanged.
- R7: Offsets 0x1E4, 0x280, 0x284 and 0x288 read as zero and ignore writes. Each access to them raises `unimpl_hit` for the one cycle after the strobe, and `addr_err` stays low.
- R8: Any other offset in the window reads zero and ignores writes. This includes the unused words inside a core group and any address with a nonzero value in bits [1:0]. Each such access raises `addr_err` for the one cycle after the strobe, and a misaligned nonzero write to a core reset word fires no start.
- R9: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and `rdata` holds the read result in that cycle. `unimpl_hit` and `addr_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 10 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read result present |
| unimpl_hit | output | 1 | Access hit an unimplemented offset |
| addr_err | output | 1 | Access hit an undecoded or misaligned offset |
| start_req | output | 4 | Per-core start pulse, one bit per core |
| start_addr | output | 32 | Entry address for the started core |
| start_el | output | 2 | Exception level for the started core |

## Verification
The assertions assume that each access is a one-cycle strobe and that `rd_en` and `wr_en` are never high in the same cycle. They also assume that the data and address are held only while the strobe is high. The stimulus keeps to this: every access drives a single strobe from one falling edge and drops it just after the next rising edge. The stimulus sweeps every aligned word in the window with a read, then with a nonzero write, then with a read again. It adds misaligned and zero-data writes aimed at the core reset words. This keeps each start, flag and read value attributable to one known access.

// File: rtl/boot_rel_pkg.sv
package boot_rel_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int EL_W   = 2;

  typedef enum logic [3:0] {
    K_BADADDR,
    K_CLUSTER_RST,
    K_SYS_RST,
    K_CORE_RST,
    K_CORE_CTRL,
    K_CORE_STAT,
    K_GATING,
    K_GEN,
    K_STANDBY,
    K_ENTRY,
    K_UNIMPL
  } reg_kind_e;

  // fixed offsets outside the per-core groups
  localparam logic [ADDR_W-1:0] OFF_CLUSTER_RST = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_SYS_RST     = 10'h140;
  localparam logic [ADDR_W-1:0] OFF_GATING      = 10'h144;
  localparam logic [ADDR_W-1:0] OFF_GEN         = 10'h184;
  localparam logic [ADDR_W-1:0] OFF_STANDBY     = 10'h1A0;
  localparam logic [ADDR_W-1:0] OFF_ENTRY       = 10'h1A4;
  localparam logic [ADDR_W-1:0] OFF_DBG         = 10'h1E4;
  localparam logic [ADDR_W-1:0] OFF_CNT_CTL     = 10'h280;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO      = 10'h284;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI      = 10'h288;

  // sub-offsets inside a core group
  localparam int SUB_RST  = 0;
  localparam int SUB_CTRL = 4;
  localparam int SUB_STAT = 8;

  // read-only and reset values
  localparam logic [DATA_W-1:0] VAL_CORE_RST  = 32'h0000_0003;
  localparam logic [DATA_W-1:0] VAL_SYS_RST   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] VAL_CORE_STAT = 32'h0000_0001;
  localparam logic [DATA_W-1:0] VAL_CORE_CTRL = 32'h0000_0000;
  localparam logic [DATA_W-1:0] VAL_GATING    = 32'h0000_010F;
  localparam logic [DATA_W-1:0] GEN_RST_VAL   = 32'h0000_0020;
  localparam logic [DATA_W-1:0] STBY_RST_VAL  = 32'h0000_0000;
  localparam logic [DATA_W-1:0] ENTRY_RST_VAL = 32'h0000_0000;
  localparam logic [EL_W-1:0]   START_EL_VAL  = 2'd3;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import boot_rel_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_BASE = 'h40,
  parameter int STRIDE_LG = 6,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  core_idx
);

  localparam int GROUP_W = ADDR_W - STRIDE_LG;

  logic [NUM_CORES-1:0] grp_hit;
  logic [STRIDE_LG-1:0] sub;

  assign sub = addr[STRIDE_LG-1:0];

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_grp
    localparam int GRP = (CORE_BASE >> STRIDE_LG) + n;
    assign grp_hit[n] = (addr[ADDR_W-1:STRIDE_LG] == GROUP_W'(GRP));
  end

  always_comb begin
    core_idx = '0;
    for (int n = 0; n < NUM_CORES; n++) begin
      if (grp_hit[n]) core_idx = IDX_W'(n);
    end
  end

  always_comb begin
    kind = K_BADADDR;
    if (addr[1:0] != 2'b00) begin
      kind = K_BADADDR;
    end else if (|grp_hit) begin
      if (sub == STRIDE_LG'(SUB_RST))       kind = K_CORE_RST;
      else if (sub == STRIDE_LG'(SUB_CTRL)) kind = K_CORE_CTRL;
      else if (sub == STRIDE_LG'(SUB_STAT)) kind = K_CORE_STAT;
      else                                  kind = K_BADADDR;
    end else begin
      case (addr)
        OFF_CLUSTER_RST: kind = K_CLUSTER_RST;
        OFF_SYS_RST:     kind = K_SYS_RST;
        OFF_GATING:      kind = K_GATING;
        OFF_GEN:         kind = K_GEN;
        OFF_STANDBY:     kind = K_STANDBY;
        OFF_ENTRY:       kind = K_ENTRY;
        OFF_DBG,
        OFF_CNT_CTL,
        OFF_CNT_LO,
        OFF_CNT_HI:      kind = K_UNIMPL;
        default:         kind = K_BADADDR;
      endcase
    end
  end

endmodule

// File: rtl/brc_cfg_regs.sv
module brc_cfg_regs
  import boot_rel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] gen_q,
  output logic [DATA_W-1:0] standby_q,
  output logic [DATA_W-1:0] entry_q
);

  logic gen_en, standby_en, entry_en;

  always_comb begin
    gen_en     = wr_en && (kind == K_GEN);
    standby_en = wr_en && (kind == K_STANDBY);
    entry_en   = wr_en && (kind == K_ENTRY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q     <= GEN_RST_VAL;
      standby_q <= STBY_RST_VAL;
      entry_q   <= ENTRY_RST_VAL;
    end else begin
      if (gen_en)     gen_q     <= wdata;
      if (standby_en) standby_q <= wdata;
      if (entry_en)   entry_q   <= wdata;
    end
  end

endmodule

// File: rtl/brc_core_start.sv
module brc_core_start
  import boot_rel_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_kind_e            kind,
  input  logic [IDX_W-1:0]     core_idx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_CORES-1:0] start_q
);

  logic                 arm;
  logic [NUM_CORES-1:0] start_d;

  assign arm = wr_en && (kind == K_CORE_RST) && (|wdata);

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    assign start_d[n] = arm && (core_idx == IDX_W'(n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= start_d;
  end

endmodule

// File: rtl/boot_release_ctrl.sv
module boot_release_ctrl
  import boot_rel_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_BASE = 'h40,
  parameter int STRIDE_LG = 6,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [9:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 rd_valid,
  output logic                 unimpl_hit,
  output logic                 addr_err,
  output logic [NUM_CORES-1:0] start_req,
  output logic [31:0]          start_addr,
  output logic [1:0]           start_el
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_n_q <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_n_q <= rst_s0;
    end
  end

  reg_kind_e         kind;
  logic [IDX_W-1:0]  core_idx;
  logic [DATA_W-1:0] gen_q, standby_q, entry_q;

  brc_decode #(
    .NUM_CORES(NUM_CORES),
    .CORE_BASE(CORE_BASE),
    .STRIDE_LG(STRIDE_LG)
  ) u_dec (
    .addr     (addr),
    .kind     (kind),
    .core_idx (core_idx)
  );

  brc_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .wr_en     (wr_en),
    .kind      (kind),
    .wdata     (wdata),
    .gen_q     (gen_q),
    .standby_q (standby_q),
    .entry_q   (entry_q)
  );

  brc_core_start #(.NUM_CORES(NUM_CORES)) u_start (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .wr_en    (wr_en),
    .kind     (kind),
    .core_idx (core_idx),
    .wdata    (wdata),
    .start_q  (start_req)
  );

  // read mux and access flags, next state
  logic [DATA_W-1:0] rdata_d;
  logic              access, unimpl_d, err_d;

  always_comb begin
    case (kind)
      K_CLUSTER_RST,
      K_SYS_RST:     rdata_d = VAL_SYS_RST;
      K_CORE_RST:    rdata_d = VAL_CORE_RST;
      K_CORE_CTRL:   rdata_d = VAL_CORE_CTRL;
      K_CORE_STAT:   rdata_d = VAL_CORE_STAT;
      K_GATING:      rdata_d = VAL_GATING;
      K_GEN:         rdata_d = gen_q;
      K_STANDBY:     rdata_d = standby_q;
      K_ENTRY:       rdata_d = entry_q;
      default:       rdata_d = '0;
    endcase
    access   = rd_en | wr_en;
    unimpl_d = access && (kind == K_UNIMPL);
    err_d    = access && (kind == K_BADADDR);
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      rdata      <= '0;
      rd_valid   <= 1'b0;
      unimpl_hit <= 1'b0;
      addr_err   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rdata_d;
      rd_valid   <= rd_en;
      unimpl_hit <= unimpl_d;
      addr_err   <= err_d;
    end
  end

  assign start_addr = entry_q;
  assign start_el   = START_EL_VAL;

endmodule

// File: rtl/boot_rel_chk.sv
module boot_rel_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [9:0]           addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic                 rd_valid,
  input logic                 unimpl_hit,
  input logic                 addr_err,
  input logic [NUM_CORES-1:0] start_req
);

  AST_RDVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);  // R9

  AST_RDVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);  // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(unimpl_hit && addr_err));  // R9

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_req));  // R3

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wdata != 32'd0) && (addr[1:0] == 2'b00) && (addr[5:0] == 6'd0)
      && (addr >= 10'h040) && (addr < 10'h140) |=> $countones(start_req) == 1);  // R3

  AST_ZERO_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wdata == 32'd0) |=> start_req == '0);  // R4

  AST_FLAG_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !unimpl_hit && !addr_err);  // R7

  AST_MISALIGNED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && (addr[1:0] != 2'b00) |=> addr_err && start_req == '0);  // R8

  AST_CLUSTER_RST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == 10'h000) |=> rdata == 32'h1);  // R5

endmodule

bind boot_release_ctrl boot_rel_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_q),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .rd_valid   (rd_valid),
  .unimpl_hit (unimpl_hit),
  .addr_err   (addr_err),
  .start_req  (start_req)
);

// File: tb/sim_boot_release_ctrl.sv
module sim_boot_release_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NCORE      = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rd_en, wr_en;
  logic [9:0]       addr;
  logic [31:0]      wdata;
  logic [31:0]      rdata;
  logic             rd_valid, unimpl_hit, addr_err;
  logic [NCORE-1:0] start_req;
  logic [31:0]      start_addr;
  logic [1:0]       start_el;

  int checks   = 0;
  int failures = 0;

  // bench model of the writable registers
  logic [31:0] m_gen, m_stby, m_entry;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_release_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .unimpl_hit(unimpl_hit),
    .addr_err(addr_err), .start_req(start_req), .start_addr(start_addr),
    .start_el(start_el)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 = normal, 1 = unimplemented, 2 = address error
  function automatic int kind_of(input int a);
    int sub;
    if (a % 4 != 0) return 2;
    if (a == 'h1E4 || a == 'h280 || a == 'h284 || a == 'h288) return 1;
    if (a == 'h000 || a == 'h140 || a == 'h144 || a == 'h184 || a == 'h1A0 || a == 'h1A4)
      return 0;
    if (a >= 'h40 && a < 'h40 + NCORE * 'h40) begin
      sub = a % 'h40;
      if (sub == 0 || sub == 4 || sub == 8) return 0;
    end
    return 2;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (kind_of(a) != 0) return 32'h0;
    if (a == 'h000 || a == 'h140) return 32'h1;
    if (a == 'h144) return 32'h10F;
    if (a == 'h184) return m_gen;
    if (a == 'h1A0) return m_stby;
    if (a == 'h1A4) return m_entry;
    case (a % 'h40)
      0:       return 32'h3;
      4:       return 32'h0;
      default: return 32'h1;
    endcase
  endfunction

  function automatic int core_of(input int a);
    if (a % 4 == 0 && a >= 'h40 && a < 'h40 + NCORE * 'h40 && a % 'h40 == 0)
      return (a - 'h40) / 'h40;
    return -1;
  endfunction

  task automatic do_read(input int a, input string req);
    int k;
    @(negedge clk);
    rd_en = 1'b1; addr = 10'(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
    k = kind_of(a);
    chk("R9", 32'(rd_valid), 32'h1);
    chk(req, rdata, exp_rd(a));
    chk(k == 1 ? "R7" : (k == 2 ? "R8" : req), {30'h0, unimpl_hit, addr_err},
        {30'h0, k == 1, k == 2});
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input string req);
    int k, c;
    logic [31:0] ent_before;
    ent_before = m_entry;
    @(negedge clk);
    wr_en = 1'b1; addr = 10'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    k = kind_of(a);
    c = (d != 0) ? core_of(a) : -1;
    if (a == 'h184) m_gen = d;
    if (a == 'h1A0) m_stby = d;
    if (a == 'h1A4) m_entry = d;
    chk("R9", 32'(rd_valid), 32'h0);
    chk(req, 32'(start_req), (c >= 0) ? (32'h1 << c) : 32'h0);
    if (c >= 0) begin
      chk("R3", start_addr, ent_before);
      chk("R3", 32'(start_el), 32'h3);
    end
    chk(k == 1 ? "R7" : (k == 2 ? "R8" : req), {30'h0, unimpl_hit, addr_err},
        {30'h0, k == 1, k == 2});
  endtask

  task automatic idle_check(input string req);
    @(posedge clk); #1;
    chk(req, {28'h0, start_req}, 32'h0);
    chk(req, {30'h0, unimpl_hit, addr_err}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_gen = 32'h20; m_stby = 32'h0; m_entry = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: idle outputs and reset values
    idle_check("R1");
    chk("R1", 32'(rd_valid), 32'h0);
    do_read('h184, "R1");
    do_read('h1A0, "R1");
    do_read('h1A4, "R1");

    // R5 R6 R7 R8: every aligned word after reset
    for (int a = 0; a < 1024; a += 4) do_read(a, "R6");

    // R2: set an entry address before the core starts
    do_write('h1A4, 32'h8000_1000, "R2");
    do_read('h1A4, "R2");

    // R3 R6 R7 R8: nonzero write to every aligned word
    for (int a = 0; a < 1024; a += 4) do_write(a, 32'hC0DE_0000 | 32'(a), "R3");

    // R2 R5 R6: read back, only the three stored words changed
    for (int a = 0; a < 1024; a += 4) do_read(a, "R6");

    // R2: all-ones and alternate patterns
    do_write('h184, 32'hFFFF_FFFF, "R2"); do_read('h184, "R2");
    do_write('h1A0, 32'h5555_AAAA, "R2"); do_read('h1A0, "R2");

    // R4: zero writes to every core reset word
    for (int n = 0; n < NCORE; n++) do_write('h40 + n * 'h40, 32'h0, "R4");

    // R3: start carries the newest entry address
    do_write('h1A4, 32'h0000_0004, "R2");
    do_write('h100, 32'h1, "R3");
    idle_check("R3");
    do_write('h40, 32'h8000_0000, "R3");

    // R8: misaligned accesses
    do_read('h185, "R8");
    do_read('h042, "R8");
    do_write('h041, 32'hFFFF_FFFF, "R8");
    do_write('h1A5, 32'h1234_5678, "R8");
    do_read('h1A4, "R8");
    do_read('h04C, "R8");

    idle_check("R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule